// File: doc/BRIEF.md
# Rate One-Half Convolutional Packet Encoder

This block takes the bytes of one packet (payload followed by its check word, both supplied by the upstream stage) on a byte-wide valid/ready stream. It turns each byte into a stream of 2-bit coded symbols using a rate one-half convolutional code with constraint length 4. Every input bit gives one symbol pair, so the coded stream carries twice the bits of the input.

When the final byte has been coded, the block appends one or two all-zero filler bytes of its own. The filler makes the count of coded bytes even and drives the encoder memory back to zero, which terminates the trellis. A packet of only one byte cannot be coded. The block drops it and pulses an error flag.

A per-packet enable, sampled with the first byte, selects the uncoded mode. In that mode each byte leaves as four raw 2-bit pairs, with no filler added.

Top module: `conv_pkt_encoder`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and `err_short` is 0. The block never accepts a byte in a cycle in which it offers a symbol.
- R2: In coded mode, bits are taken MSB first. The encoder memory is zero at the start of each packet. For current bit c and previous bits p1, p2, p3 (p1 most recent), `out_sym[1]` = c^p1^p2^p3 (generator octal 17) and `out_sym[0]` = c^p1^p3 (generator octal 15).
- R3: In coded mode, each input byte produces exactly 8 symbol pairs.
- R4: After the last coded byte, zero filler bytes are coded: one if the packet had an odd byte count, two if it had an even count. After the final pair, the encoder memory is zero.
- R5: `out_last` is 1 only on the final pair of a packet: the last pair of the last filler byte in coded mode, or the last pair of the last byte in uncoded mode. It is never 1 without `out_valid`.
- R6: A coded-mode packet whose first byte carries `in_last` produces no symbols. It raises `err_short` for exactly one cycle, in the cycle after that byte is accepted.
- R7: With `code_en` = 0 at the first byte, each byte is sent as four pairs, bits [7:6] first and bits [1:0] last, with no filler. A one-byte packet is allowed in this mode.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_sym` and `out_last` hold their values into the next cycle.
- R9: `code_en` is sampled only with the first byte of a packet. Changing it during the rest of the packet has no effect on that packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| code_en | input | 1 | 1 selects coding for the packet that is starting |
| in_data | input | 8 | Input byte |
| in_valid | input | 1 | Input byte is present |
| in_last | input | 1 | Input byte is the last of the packet |
| in_ready | output | 1 | Block accepts an input byte |
| out_sym | output | 2 | Symbol pair; bit 1 is the first-sent bit |
| out_valid | output | 1 | Symbol pair is present |
| out_last | output | 1 | Final pair of the packet |
| out_ready | input | 1 | Downstream accepts the pair |
| err_short | output | 1 | One-cycle pulse for a rejected one-byte coded packet |

## Verification
Two events can land in the same cycle: a downstream stall, and the byte-boundary step in which the block moves from the last data byte into filler, or from one filler byte to the next. The bench keeps `out_ready` low at random for about a quarter of cycles across many random-length packets, so stalls hit these boundary pairs regularly. Each packet's captured symbol stream, including the position of `out_last`, is compared pair by pair against a bench-side model of the code. A bench-side counter also flags any pair that changes while it is held.

// File: rtl/conv_enc_pkg.sv
package conv_enc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DATA = 2'd2,
        ST_PAD  = 2'd3
    } enc_state_e;
endpackage

// File: rtl/conv_enc_core.sv
// Combinational convolutional kernel: one input bit -> one symbol pair
module conv_enc_core #(
    parameter int          K   = 4,
    parameter logic [K-1:0] G_A = 4'o17,
    parameter logic [K-1:0] G_B = 4'o15
) (
    input  logic         bit_in,
    input  logic [K-2:0] mem_in,
    output logic [1:0]   pair,
    output logic [K-2:0] mem_nxt
);
    localparam int MEM = K - 1;

    logic [K-1:0] window;
    assign window = {bit_in, mem_in};

    for (genvar g = 0; g < 2; g++) begin : g_poly
        localparam logic [K-1:0] TAPS = (g == 0) ? G_A : G_B;
        assign pair[1-g] = ^(window & TAPS);
    end

    if (MEM > 1) begin : g_shift
        assign mem_nxt = {bit_in, mem_in[MEM-1:1]};
    end else begin : g_single
        assign mem_nxt = bit_in;
    end
endmodule

// File: rtl/enc_pad_plan.sv
// Number of zero filler bytes needed to reach an even total with at least one
module enc_pad_plan #(
    parameter int CNT_W = 2
) (
    input  logic             odd_count,
    output logic [CNT_W-1:0] pad_bytes
);
    assign pad_bytes = odd_count ? CNT_W'(1) : CNT_W'(2);
endmodule

// File: rtl/conv_pkt_encoder.sv
module conv_pkt_encoder #(
    parameter int           DW  = 8,
    parameter int           K   = 4,
    parameter logic [K-1:0] G_A = 4'o17,
    parameter logic [K-1:0] G_B = 4'o15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          code_en,
    input  logic [DW-1:0] in_data,
    input  logic          in_valid,
    input  logic          in_last,
    output logic          in_ready,
    output logic [1:0]    out_sym,
    output logic          out_valid,
    output logic          out_last,
    input  logic          out_ready,
    output logic          err_short
);
    import conv_enc_pkg::*;

    localparam int MEM   = K - 1;
    localparam int IDX_W = $clog2(DW);
    localparam int PAD_W = 2;
    localparam logic [IDX_W-1:0] LAST_CODED = IDX_W'(DW - 1);
    localparam logic [IDX_W-1:0] LAST_RAW   = IDX_W'(DW / 2 - 1);

    typedef struct packed {
        enc_state_e       st;
        logic [DW-1:0]    shreg;
        logic [IDX_W-1:0] idx;
        logic             last_byte;
        logic             coded;
        logic             odd;
        logic [PAD_W-1:0] pads_left;
        logic [MEM-1:0]   mem;
        logic             err;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic             enc_pair_valid;
    logic [1:0]       coded_pair;
    logic [MEM-1:0]   mem_next;
    logic [PAD_W-1:0] pad_need;
    logic             final_pair;
    logic             accept;
    logic             fire;

    conv_enc_core #(.K(K), .G_A(G_A), .G_B(G_B)) u_core (
        .bit_in  (ctx_q.shreg[DW-1]),
        .mem_in  (ctx_q.mem),
        .pair    (coded_pair),
        .mem_nxt (mem_next)
    );

    enc_pad_plan #(.CNT_W(PAD_W)) u_pad (
        .odd_count (ctx_q.odd),
        .pad_bytes (pad_need)
    );

    assign in_ready       = (ctx_q.st == ST_IDLE) || (ctx_q.st == ST_WAIT);
    assign enc_pair_valid = (ctx_q.st == ST_DATA) || (ctx_q.st == ST_PAD);
    assign out_valid      = enc_pair_valid;
    assign accept         = in_valid && in_ready;
    assign fire           = enc_pair_valid && out_ready;
    assign final_pair     = ctx_q.coded ? (ctx_q.idx == LAST_CODED)
                                        : (ctx_q.idx == LAST_RAW);
    assign out_sym        = ctx_q.coded ? coded_pair : ctx_q.shreg[DW-1:DW-2];
    assign out_last       = final_pair &&
                            (((ctx_q.st == ST_DATA) && ctx_q.last_byte && !ctx_q.coded) ||
                             ((ctx_q.st == ST_PAD) && (ctx_q.pads_left == PAD_W'(1))));
    assign err_short      = ctx_q.err;

    always_comb begin
        ctx_d     = ctx_q;
        ctx_d.err = 1'b0;
        unique case (ctx_q.st)
            ST_IDLE: begin
                if (accept) begin
                    if (code_en && in_last) begin
                        ctx_d.err = 1'b1;
                    end else begin
                        ctx_d.st        = ST_DATA;
                        ctx_d.shreg     = in_data;
                        ctx_d.idx       = '0;
                        ctx_d.last_byte = in_last;
                        ctx_d.coded     = code_en;
                        ctx_d.odd       = 1'b1;
                        ctx_d.mem       = '0;
                        ctx_d.pads_left = '0;
                    end
                end
            end
            ST_WAIT: begin
                if (accept) begin
                    ctx_d.st        = ST_DATA;
                    ctx_d.shreg     = in_data;
                    ctx_d.idx       = '0;
                    ctx_d.last_byte = in_last;
                    ctx_d.odd       = ~ctx_q.odd;
                end
            end
            ST_DATA, ST_PAD: begin
                if (fire) begin
                    if (ctx_q.coded) begin
                        ctx_d.mem   = mem_next;
                        ctx_d.shreg = {ctx_q.shreg[DW-2:0], 1'b0};
                    end else begin
                        ctx_d.shreg = {ctx_q.shreg[DW-3:0], 2'b00};
                    end
                    ctx_d.idx = ctx_q.idx + IDX_W'(1);
                    if (final_pair) begin
                        ctx_d.idx   = '0;
                        ctx_d.shreg = '0;
                        if (ctx_q.st == ST_DATA) begin
                            if (!ctx_q.last_byte) begin
                                ctx_d.st = ST_WAIT;
                            end else if (ctx_q.coded) begin
                                ctx_d.st        = ST_PAD;
                                ctx_d.pads_left = pad_need;
                            end else begin
                                ctx_d.st = ST_IDLE;
                            end
                        end else begin
                            if (ctx_q.pads_left == PAD_W'(1)) begin
                                ctx_d.st        = ST_IDLE;
                                ctx_d.pads_left = '0;
                            end else begin
                                ctx_d.pads_left = ctx_q.pads_left - PAD_W'(1);
                            end
                        end
                    end
                end
            end
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    logic [MEM-1:0] enc_mem;
    logic           enc_coded;
    assign enc_mem   = ctx_q.mem;
    assign enc_coded = ctx_q.coded;
endmodule

// File: rtl/conv_pkt_encoder_chk.sv
module conv_pkt_encoder_chk #(
    parameter int MEM = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_ready,
    input logic           out_valid,
    input logic           out_ready,
    input logic [1:0]     out_sym,
    input logic           out_last,
    input logic           err_short,
    input logic [MEM-1:0] enc_mem,
    input logic           enc_coded
);
    // R1: no byte taken while a pair is offered
    a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    // R8: held pair stays put under backpressure
    a_r8_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_sym) && $stable(out_last)));

    // R5: end marker only on an offered pair
    a_r5_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R6: a rejected packet emits nothing alongside the error pulse
    a_r6_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
        err_short |-> !out_valid);

    // R4: trellis is terminated once the final coded pair is taken
    a_r4_flushed: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last && enc_coded) |=> (enc_mem == '0));
endmodule

bind conv_pkt_encoder conv_pkt_encoder_chk #(.MEM(MEM)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_sym   (out_sym),
    .out_last  (out_last),
    .err_short (err_short),
    .enc_mem   (enc_mem),
    .enc_coded (enc_coded)
);

// File: tb/sim_conv_pkt_encoder.sv
module sim_conv_pkt_encoder;
    typedef logic [2:0] sym_q_t[$];
    typedef logic [7:0] byte_q_t[$];

    logic       clk = 1'b0;
    logic       rst_n;
    logic       code_en;
    logic [7:0] in_data;
    logic       in_valid;
    logic       in_last;
    logic       in_ready;
    logic [1:0] out_sym;
    logic       out_valid;
    logic       out_last;
    logic       out_ready;
    logic       err_short;

    always #10 clk = ~clk;

    conv_pkt_encoder u0 (
        .clk(clk), .rst_n(rst_n), .code_en(code_en), .in_data(in_data),
        .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
        .out_sym(out_sym), .out_valid(out_valid), .out_last(out_last),
        .out_ready(out_ready), .err_short(err_short)
    );

    int     n_checks = 0;
    int     n_fail   = 0;
    sym_q_t got;
    bit     got_last_seen;
    int     err_seen   = 0;
    bit     stall_en   = 0;
    bit     gap_en     = 0;
    int     stall_viol = 0;
    bit     prev_stall = 0;
    logic [2:0] prev_val;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Model of the code and framing, from the requirements
    function automatic sym_q_t build(input byte_q_t b, input bit coded);
        sym_q_t   e;
        byte_q_t  all;
        logic     p1, p2, p3, x;
        int       n;
        all = b;
        n = b.size();
        if (!coded) begin
            for (int i = 0; i < n; i++)
                for (int j = 3; j >= 0; j--)
                    e.push_back({(i == n-1 && j == 0), all[i][2*j+1], all[i][2*j]});
            return e;
        end
        all.push_back(8'h00);
        if (n % 2 == 0) all.push_back(8'h00);
        p1 = 0; p2 = 0; p3 = 0;
        for (int i = 0; i < all.size(); i++)
            for (int j = 7; j >= 0; j--) begin
                x = all[i][j];
                e.push_back({(i == all.size()-1 && j == 0), x^p1^p2^p3, x^p1^p3});
                p3 = p2; p2 = p1; p1 = x;
            end
        return e;
    endfunction

    always @(negedge clk) begin
        out_ready = stall_en ? ($urandom_range(3) != 0) : 1'b1;
    end

    always @(negedge clk) begin
        #5;
        if (rst_n) begin
            if (prev_stall && !(out_valid && {out_last, out_sym} == prev_val)) stall_viol++;
            prev_stall = out_valid && !out_ready;
            prev_val   = {out_last, out_sym};
            if (out_valid && out_ready) begin
                got.push_back({out_last, out_sym});
                if (out_last) got_last_seen = 1;
            end
            if (err_short) err_seen++;
        end
    end

    task automatic send_byte(input logic [7:0] d, input bit l, input bit ce);
        @(negedge clk);
        in_data = d; in_last = l; in_valid = 1'b1; code_en = ce;
        forever begin
            #5;
            if (in_ready) break;
            @(negedge clk);
        end
        @(posedge clk);
        #1 in_valid = 1'b0;
        if (gap_en) repeat ($urandom_range(2)) @(negedge clk);
    endtask

    task automatic run_pkt(input byte_q_t b, input bit mode, input bit toggle, input string tag);
        sym_q_t e;
        int     bad;
        int     lastpos;
        e = build(b, mode);
        got.delete();
        got_last_seen = 0;
        for (int i = 0; i < b.size(); i++)
            send_byte(b[i], i == b.size()-1, (i == 0) ? mode : (toggle ? ~mode : mode));
        for (int t = 0; t < 3000 && !got_last_seen; t++) @(negedge clk);
        repeat (2) @(negedge clk);
        check(got.size() == e.size(), {tag, " pair count"}, got.size(), e.size());
        bad = -1;
        lastpos = -1;
        for (int i = 0; i < got.size() && i < e.size(); i++) begin
            if (got[i][1:0] != e[i][1:0] && bad < 0) bad = i;
            if (got[i][2] && lastpos < 0) lastpos = i;
        end
        check(bad < 0, {tag, " symbols"}, (bad < 0) ? 0 : int'(got[bad][1:0]),
              (bad < 0) ? 0 : int'(e[bad][1:0]));
        check(lastpos == e.size()-1, "R5 last marker position", lastpos, e.size()-1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        byte_q_t b;
        int      e0;
        void'($urandom(32'd1234));
        rst_n = 0; code_en = 1; in_data = 0; in_valid = 0; in_last = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #5;
        check(out_valid == 0, "R1 reset out_valid", out_valid, 0);
        check(in_ready == 1, "R1 reset in_ready", in_ready, 1);
        check(err_short == 0, "R1 reset err_short", err_short, 0);

        // R4: even count -> two filler bytes; R2 known pattern
        b = '{8'hFF, 8'h00};
        run_pkt(b, 1, 0, "R2 R4 even count");
        // R4: odd count -> one filler byte
        b = '{8'hA5, 8'h3C, 8'h81};
        run_pkt(b, 1, 0, "R3 R4 odd count");

        // R6: one-byte coded packet is rejected
        e0 = err_seen;
        got.delete();
        send_byte(8'h5A, 1, 1);
        repeat (20) @(negedge clk);
        check(err_seen == e0 + 1, "R6 error pulse count", err_seen - e0, 1);
        check(got.size() == 0, "R6 no symbols", got.size(), 0);

        // R7: one-byte and multi-byte uncoded packets
        b = '{8'hC6};
        run_pkt(b, 0, 0, "R7 single raw byte");
        b = '{8'h12, 8'hEF, 8'h70};
        run_pkt(b, 0, 0, "R7 raw packet");

        // R9: enable toggled after the first byte
        b = '{8'h96, 8'h4B, 8'hD2, 8'h0F};
        run_pkt(b, 1, 1, "R9 coded, enable dropped mid-packet");
        b = '{8'h33, 8'hCC};
        run_pkt(b, 0, 1, "R9 raw, enable raised mid-packet");

        // Random traffic under backpressure and input gaps
        stall_en = 1; gap_en = 1;
        for (int p = 0; p < 40; p++) begin
            int len;
            bit m;
            len = $urandom_range(7, 1);
            m = (len == 1) ? 1'b0 : 1'($urandom_range(1));
            b.delete();
            for (int i = 0; i < len; i++) b.push_back(8'($urandom));
            run_pkt(b, m, 1'($urandom_range(1)), m ? "R2 R3 R4 random coded" : "R7 random raw");
        end
        stall_en = 0; gap_en = 0;
        check(stall_viol == 0, "R8 held pair changed under stall", stall_viol, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule